// File: doc/BRIEF.md
# In-Memory Compute Microkernel Sequencer

This block is a small processing unit placed next to one memory bank. It runs a short stored program, called a microkernel, on the data that moves through the bank. The host never sends compute commands. It loads the program while the unit is idle, pulses a start input, and then issues ordinary reads and writes to the bank. Each access that arrives while the unit is busy executes exactly one instruction, and that instruction works on the data beat carried by the access. For a write the beat is the host's write data. For a read it is the data the bank returns.

The unit has three kinds of storage. An operand file A holds eight vector registers. An accumulator file B holds eight vectors of 32-bit lanes. A 32-entry program buffer holds the instructions. A beat is 16 lanes of 16-bit signed integers. The instructions are:

- load a beat into an A register;
- a per-lane multiply-accumulate into B;
- a counted backward jump that runs when the program counter reaches it and uses no access of its own;
- a fill that writes a B register, truncated to 16 bits per lane, onto the bank;
- an exit.

In address-aligned mode the multiply-accumulate takes its register indices from the access's column address. A matrix-vector product can then be written as one looped instruction.

Top module: `pim_seq`

## Requirements
- R1: After reset, `busy` and `err` are 0, the program buffer counts as empty, and every A and B register is zero.
- R2: While `busy` is 0, an access passes straight through: `bank_we` equals `acc_valid & acc_write` and `bank_wdata` equals `acc_wdata`. It changes no A or B register. This includes accesses after an exit and before the next start.
- R3: A `start` pulse while idle sets `err` and leaves `busy` at 0 if no instruction has been written since reset. Otherwise it clears `err`, sets `busy` on the next cycle and begins at program address 0.
- R4: Program writes (`prog_we`) take effect only while `busy` is 0. A write issued while busy leaves the stored program unchanged.
- R5: The instruction word is 24 bits: opcode [23:21], address-aligned flag [20], A index [19:17], B index [16:14], signed jump offset [13:8], repeat count [7:0]. Opcodes are MOV=1, MAC=2, JUMP=3, FILL=4, EXIT=5, and any other value is a no-op. Lane l of a beat occupies bits [16l+15:16l]. MOV copies the beat into A[A index]. The beat is `acc_wdata` on a write access and `bank_rdata` on a read.
- R6: MAC adds, lane by lane, the signed product of the beat lane and the A lane into the 32-bit B lane, wrapping modulo 2^32. Successive MACs to the same B register accumulate.
- R7: With the address-aligned flag set, MAC uses `acc_col[2:0]` as both the A and the B index instead of the instruction fields.
- R8: When the program counter advances onto a JUMP in the same cycle as an executed access, the JUMP is resolved in that cycle. A JUMP with offset -1 and count N makes the preceding instruction execute N+1 times in total. After that the program falls through to the instruction after the JUMP.
- R9: On an access that executes FILL, `bank_we` is 1 and each lane of `bank_wdata` is the low 16 bits of the matching lane of B[B index], whatever the access direction.
- R10: An access that executes EXIT passes through as in R2 and clears `busy` on the next cycle. `busy` never falls without an access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Program buffer write strobe |
| prog_addr | input | 5 | Program buffer write address |
| prog_data | input | 24 | Instruction word to store |
| start | input | 1 | Begin executing the stored microkernel |
| acc_valid | input | 1 | A host access to the bank is present this cycle |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| acc_col | input | 8 | Column index of the access |
| acc_wdata | input | 256 | Host write data beat |
| bank_rdata | input | 256 | Data beat returned by the bank on a read |
| bank_we | output | 1 | Write strobe into the bank |
| bank_wdata | output | 256 | Data beat written into the bank |
| busy | output | 1 | A microkernel is running |
| err | output | 1 | Start was requested with an empty program buffer |

## Verification
Two things can happen in the same clock edge: the access that executes a MAC, and the resolution of the JUMP the program counter then lands on. That edge both accumulates into B and either decrements the loop counter or falls through. The matrix-vector test drives eight address-aligned MAC reads at columns 0 to 7 behind eight MOVs, with a repeat count of 7. It then checks that the sixteenth access is still a plain read, that the seventeenth is the FILL, and that the filled value equals the product for column 3 alone. A miscount, a jump that uses up an access, or indices taken from the instruction would each change one of those values.

// File: rtl/pim_seq_pkg.sv
package pim_seq_pkg;
    localparam int LANES      = 16;
    localparam int LANE_W     = 16;
    localparam int ACC_W      = 32;
    localparam int RF_DEPTH   = 8;
    localparam int PROG_DEPTH = 32;
    localparam int LOOP_W     = 8;
    localparam int OFS_W      = 6;
    localparam int COL_W      = 8;
    localparam int BEAT_W     = LANES * LANE_W;
    localparam int IDX_W      = $clog2(RF_DEPTH);
    localparam int PC_W       = $clog2(PROG_DEPTH);

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_MOV  = 3'd1,
        OP_MAC  = 3'd2,
        OP_JUMP = 3'd3,
        OP_FILL = 3'd4,
        OP_EXIT = 3'd5
    } op_e;

    typedef struct packed {
        op_e                     op;
        logic                    aam;
        logic [IDX_W-1:0]        ra;
        logic [IDX_W-1:0]        rb;
        logic signed [OFS_W-1:0] ofs;
        logic [LOOP_W-1:0]       cnt;
    } instr_t;

    localparam int INSTR_W = $bits(instr_t);

    typedef logic [LANES-1:0][LANE_W-1:0] beat_t;
    typedef logic [LANES-1:0][ACC_W-1:0]  acc_vec_t;

    function automatic logic [ACC_W-1:0] mac_lane(input logic [ACC_W-1:0]  acc,
                                                  input logic [LANE_W-1:0] x,
                                                  input logic [LANE_W-1:0] y);
        logic signed [2*LANE_W-1:0] prod;
        prod = $signed(x) * $signed(y);
        return acc + ACC_W'(prod);
    endfunction
endpackage

// File: rtl/pim_prog_buf.sv
module pim_prog_buf
    import pim_seq_pkg::*;
#(
    parameter int DEPTH = PROG_DEPTH,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  instr_t        wr_data,
    input  logic [AW-1:0] rd_addr_cur,
    output instr_t        rd_cur,
    input  logic [AW-1:0] rd_addr_nxt,
    output instr_t        rd_nxt,
    output logic          loaded
);
    instr_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)        loaded <= 1'b0;
        else if (wr_en) loaded <= 1'b1;
    end

    assign rd_cur = mem[rd_addr_cur];
    assign rd_nxt = mem[rd_addr_nxt];
endmodule

// File: rtl/pim_regfile.sv
module pim_regfile
    import pim_seq_pkg::*;
#(
    parameter int DEPTH = RF_DEPTH,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mov_en,
    input  logic [IW-1:0] mov_idx,
    input  logic          mac_en,
    input  logic [IW-1:0] mac_a_idx,
    input  logic [IW-1:0] mac_b_idx,
    input  beat_t         beat,
    input  logic [IW-1:0] fill_idx,
    output beat_t         fill_beat
);
    beat_t    a_q [DEPTH];
    acc_vec_t b_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                a_q[i] <= '0;
                b_q[i] <= '0;
            end
        end else begin
            if (mov_en) a_q[mov_idx] <= beat;
            if (mac_en) begin
                for (int l = 0; l < LANES; l++)
                    b_q[mac_b_idx][l] <= mac_lane(b_q[mac_b_idx][l], beat[l], a_q[mac_a_idx][l]);
            end
        end
    end

    for (genvar gl = 0; gl < LANES; gl++) begin : g_fill
        assign fill_beat[gl] = b_q[fill_idx][gl][LANE_W-1:0];
    end
endmodule

// File: rtl/pim_ctrl.sv
module pim_ctrl
    import pim_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            acc_valid,
    input  logic            loaded,
    input  instr_t          cur_ins,
    input  instr_t          nxt_ins,
    output logic [PC_W-1:0] pc,
    output logic [PC_W-1:0] pc_step,
    output logic            busy,
    output logic            err,
    output logic            exec
);
    logic [LOOP_W-1:0] lc_q, lc_n, lc_cur;
    logic              lc_act_q, lc_act_n;
    logic [PC_W-1:0]   pc_n;

    assign exec    = busy & acc_valid;
    assign pc_step = pc + PC_W'(1);
    assign lc_cur  = lc_act_q ? lc_q : nxt_ins.cnt;

    always_comb begin
        pc_n     = pc_step;
        lc_n     = lc_q;
        lc_act_n = lc_act_q;
        if (nxt_ins.op == OP_JUMP) begin
            if (lc_cur != '0) begin
                pc_n     = pc_step + PC_W'(nxt_ins.ofs);
                lc_n     = lc_cur - LOOP_W'(1);
                lc_act_n = 1'b1;
            end else begin
                pc_n     = pc_step + PC_W'(1);
                lc_act_n = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc       <= '0;
            lc_q     <= '0;
            lc_act_q <= 1'b0;
            busy     <= 1'b0;
            err      <= 1'b0;
        end else if (!busy) begin
            if (start) begin
                if (loaded) begin
                    busy     <= 1'b1;
                    err      <= 1'b0;
                    pc       <= '0;
                    lc_act_q <= 1'b0;
                end else begin
                    err <= 1'b1;
                end
            end
        end else if (exec) begin
            if (cur_ins.op == OP_EXIT) begin
                busy <= 1'b0;
            end else begin
                pc       <= pc_n;
                lc_q     <= lc_n;
                lc_act_q <= lc_act_n;
            end
        end
    end
endmodule

// File: rtl/pim_seq.sv
module pim_seq
    import pim_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_we,
    input  logic [PC_W-1:0]   prog_addr,
    input  logic [INSTR_W-1:0] prog_data,
    input  logic              start,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [COL_W-1:0]  acc_col,
    input  logic [BEAT_W-1:0] acc_wdata,
    input  logic [BEAT_W-1:0] bank_rdata,
    output logic              bank_we,
    output logic [BEAT_W-1:0] bank_wdata,
    output logic              busy,
    output logic              err
);
    instr_t          cur_ins, nxt_ins;
    logic [PC_W-1:0] pc, pc_step;
    logic            prog_loaded, exec;
    logic [2:0]      cur_op;
    beat_t           beat, fill_beat;
    logic            do_mov, do_mac, do_fill;
    logic [IDX_W-1:0] mac_a, mac_b;

    pim_prog_buf #(.DEPTH(PROG_DEPTH)) u_prog (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (prog_we & ~busy),
        .wr_addr    (prog_addr),
        .wr_data    (instr_t'(prog_data)),
        .rd_addr_cur(pc),
        .rd_cur     (cur_ins),
        .rd_addr_nxt(pc_step),
        .rd_nxt     (nxt_ins),
        .loaded     (prog_loaded)
    );

    pim_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .acc_valid(acc_valid),
        .loaded   (prog_loaded),
        .cur_ins  (cur_ins),
        .nxt_ins  (nxt_ins),
        .pc       (pc),
        .pc_step  (pc_step),
        .busy     (busy),
        .err      (err),
        .exec     (exec)
    );

    assign cur_op  = cur_ins.op;
    assign beat    = acc_write ? beat_t'(acc_wdata) : beat_t'(bank_rdata);
    assign do_mov  = exec && (cur_ins.op == OP_MOV);
    assign do_mac  = exec && (cur_ins.op == OP_MAC);
    assign do_fill = exec && (cur_ins.op == OP_FILL);
    assign mac_a   = cur_ins.aam ? acc_col[IDX_W-1:0] : cur_ins.ra;
    assign mac_b   = cur_ins.aam ? acc_col[IDX_W-1:0] : cur_ins.rb;

    pim_regfile #(.DEPTH(RF_DEPTH)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .mov_en   (do_mov),
        .mov_idx  (cur_ins.ra),
        .mac_en   (do_mac),
        .mac_a_idx(mac_a),
        .mac_b_idx(mac_b),
        .beat     (beat),
        .fill_idx (cur_ins.rb),
        .fill_beat(fill_beat)
    );

    assign bank_we    = do_fill ? 1'b1 : (acc_valid & acc_write);
    assign bank_wdata = do_fill ? BEAT_W'(fill_beat) : acc_wdata;
endmodule

// File: rtl/pim_seq_chk.sv
module pim_seq_chk
    import pim_seq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [BEAT_W-1:0] acc_wdata,
    input logic              bank_we,
    input logic [BEAT_W-1:0] bank_wdata,
    input logic              busy,
    input logic              err,
    input logic              loaded,
    input logic [2:0]        cur_op,
    input logic [PC_W-1:0]   pc
);
    p_reset_clear_r1: assert property (@(posedge clk) rst |=> (!busy && !err));

    p_idle_pass_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && acc_valid) |-> (bank_we == acc_write && bank_wdata == acc_wdata));

    p_empty_err_r3: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !loaded) |=> (err && !busy));

    p_start_run_r3: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && loaded) |=> (busy && !err && pc == '0));

    p_pc_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !acc_valid) |=> $stable(pc));

    p_fill_we_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && acc_valid && cur_op == 3'd4) |-> bank_we);

    p_exit_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && acc_valid && cur_op == 3'd5) |=> !busy);

    p_busy_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && !acc_valid) |=> busy);
endmodule

bind pim_seq pim_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_wdata (acc_wdata),
    .bank_we   (bank_we),
    .bank_wdata(bank_wdata),
    .busy      (busy),
    .err       (err),
    .loaded    (prog_loaded),
    .cur_op    (cur_op),
    .pc        (pc)
);

// File: tb/pim_seq_bench.sv
module pim_seq_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         prog_we = 1'b0;
    logic [4:0]   prog_addr = '0;
    logic [23:0]  prog_data = '0;
    logic         start = 1'b0;
    logic         acc_valid = 1'b0;
    logic         acc_write = 1'b0;
    logic [7:0]   acc_col = '0;
    logic [255:0] acc_wdata = '0;
    logic [255:0] bank_rdata = '0;
    logic         bank_we;
    logic [255:0] bank_wdata;
    logic         busy;
    logic         err;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pim_seq u_pim_seq (
        .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_data(prog_data), .start(start), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_col(acc_col), .acc_wdata(acc_wdata),
        .bank_rdata(bank_rdata), .bank_we(bank_we), .bank_wdata(bank_wdata),
        .busy(busy), .err(err)
    );

    function automatic logic [23:0] mk(input int op, input int aam, input int ra,
                                       input int rb, input int ofs, input int cnt);
        logic [2:0] o = op[2:0];
        logic [5:0] f = ofs[5:0];
        return {o, aam[0], ra[2:0], rb[2:0], f, cnt[7:0]};
    endfunction

    function automatic logic [255:0] vec(input int base, input int step);
        logic [255:0] v;
        for (int l = 0; l < 16; l++) begin
            int x = base + step * l;
            v[16*l +: 16] = x[15:0];
        end
        return v;
    endfunction

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic load(input int addr, input logic [23:0] w);
        @(negedge clk);
        prog_we = 1'b1; prog_addr = addr[4:0]; prog_data = w;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic access(input logic wr, input int col, input logic [255:0] wd,
                          input logic [255:0] rd, output logic we, output logic [255:0] o);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_col = col[7:0];
        acc_wdata = wd; bank_rdata = rd;
        #5;
        we = bank_we; o = bank_wdata;
        @(posedge clk); #1;
        acc_valid = 1'b0;
    endtask

    task automatic t_reset_and_idle();
        logic we; logic [255:0] o;
        do_reset();
        chk("R1 busy", 256'(busy), 256'(0));
        chk("R1 err", 256'(err), 256'(0));
        access(1'b1, 0, vec(5, 1), '0, we, o);
        chk("R2 idle write we", 256'(we), 256'(1));
        chk("R2 idle write data", o, vec(5, 1));
        access(1'b0, 0, vec(9, 2), vec(1, 1), we, o);
        chk("R2 idle read we", 256'(we), 256'(0));
        chk("R2 idle read data", o, vec(9, 2));
        pulse_start();
        chk("R3 empty err", 256'(err), 256'(1));
        chk("R3 empty busy", 256'(busy), 256'(0));
    endtask

    task automatic t_mov_mac_fill();
        logic we; logic [255:0] o, exp;
        do_reset();
        load(0, mk(1, 0, 0, 0, 0, 0));
        load(1, mk(2, 0, 0, 1, 0, 0));
        load(2, mk(2, 0, 0, 1, 0, 0));
        load(3, mk(4, 0, 0, 1, 0, 0));
        load(4, mk(5, 0, 0, 0, 0, 0));
        pulse_start();
        chk("R3 start busy", 256'(busy), 256'(1));
        chk("R3 start err", 256'(err), 256'(0));
        access(1'b1, 0, vec(-8, 1), vec(77, 0), we, o);
        access(1'b0, 0, vec(99, 3), vec(1, 3), we, o);
        access(1'b1, 0, vec(2, -1), vec(55, 0), we, o);
        chk("R6 mac we", 256'(we), 256'(1));
        access(1'b0, 0, '0, vec(3, 3), we, o);
        for (int l = 0; l < 16; l++) begin
            int x = l - 8;
            int acc = x * (1 + 3 * l) + x * (2 - l);
            exp[16*l +: 16] = acc[15:0];
        end
        chk("R9 fill we", 256'(we), 256'(1));
        chk("R5 R6 R9 fill data", o, exp);
        access(1'b1, 0, vec(40, 2), '0, we, o);
        chk("R10 exit passthrough", o, vec(40, 2));
        chk("R10 exit idle", 256'(busy), 256'(0));
    endtask

    task automatic t_gemv();
        logic we; logic [255:0] o, exp;
        do_reset();
        for (int k = 0; k < 8; k++) load(k, mk(1, 0, k, 0, 0, 0));
        load(8, mk(2, 1, 0, 0, 0, 0));
        load(9, mk(3, 0, 0, 0, -1, 7));
        load(10, mk(4, 0, 0, 3, 0, 0));
        load(11, mk(5, 0, 0, 0, 0, 0));
        pulse_start();
        for (int k = 0; k < 8; k++) access(1'b0, 0, '0, vec(k + 1, k + 2), we, o);
        for (int c = 0; c < 8; c++) access(1'b0, c, '0, vec(c - 3, 2), we, o);
        chk("R8 last mac is read", 256'(we), 256'(0));
        chk("R8 still busy", 256'(busy), 256'(1));
        access(1'b0, 0, '0, '0, we, o);
        for (int l = 0; l < 16; l++) begin
            int a = 4 + 5 * l;
            int m = 0 + 2 * l;
            int p = a * m;
            exp[16*l +: 16] = p[15:0];
        end
        chk("R8 fill after loop", 256'(we), 256'(1));
        chk("R7 aligned index", o, exp);
        access(1'b0, 0, '0, '0, we, o);
        chk("R10 gemv exit", 256'(busy), 256'(0));
        access(1'b0, 3, '0, vec(11, 1), we, o);
        access(1'b0, 3, '0, vec(12, 1), we, o);
        access(1'b1, 3, vec(7, 7), vec(1, 1), we, o);
        chk("R2 post exit data", o, vec(7, 7));
        load(0, mk(4, 0, 0, 3, 0, 0));
        load(1, mk(5, 0, 0, 0, 0, 0));
        pulse_start();
        load(1, mk(4, 0, 0, 3, 0, 0));
        access(1'b0, 0, '0, '0, we, o);
        chk("R2 regs untouched after exit", o, exp);
        access(1'b0, 0, '0, '0, we, o);
        chk("R4 busy write ignored", 256'(busy), 256'(0));
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset_and_idle();
        t_mov_mac_fill();
        t_gemv();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule